// File: doc/BRIEF.md
# Serial Status Readback Responder

This block is a read-only slave on a two-wire serial bus. A bus master addresses it, and the block answers with one status byte. The byte packs a sticky power-up indicator, a loop-lock level, an automatic-gain-active level and a 3-bit converter code into a fixed layout. The block samples the clock and data lines on its own system clock. It finds START and STOP conditions and compares the incoming address byte with a fixed five-bit prefix plus two bits taken from strap pins.

After a read request that matches, the block pulls the data line low for the acknowledge slot. It then shifts status bytes out, most significant bit first, for as long as the master keeps acknowledging. Each byte is captured fresh when it starts. A byte that the master does not acknowledge ends the read. The block then releases the line and clears its power-up indicator. That indicator stays cleared until the next reset.

Top module: `i2c_stat_port`

## Requirements
- R1: While reset is held and directly after it, `sda_oe` is 0 and the power-up indicator is 1.
- R2: An address byte equal to 1,1,0,0,0,`addr_sel[1]`,`addr_sel[0]`,1 (MSB first, last bit = read) causes the block to pull SDA low during the ninth clock.
- R3: The status byte is sent MSB first as {power-up, `pll_lock`, 1, 1, `agc_active`, `adc_code[2]`, `adc_code[1]`, `adc_code[0]`}. Here 1 means the line is released and 0 means the line is pulled low.
- R4: `sda_oe` changes value only while the synchronised SCL is low.
- R5: A master acknowledge (SDA low in the ninth clock of a data byte) makes the block send another byte. Every byte holds the input levels captured at the SCL falling edge that starts it. Input changes during a byte do not alter that byte.
- R6: A master non-acknowledge ends the read. SDA is released, and the power-up indicator reads 0 in every later byte until reset.
- R7: A START received in the middle of a data byte abandons it. The block releases SDA and decodes a new address byte, and the power-up indicator keeps its value.
- R8: A non-matching address or a write request (last bit 0) gets no acknowledge. SDA then stays released on every later clock until the next START.
- R9: A STOP received in the middle of a data byte returns the block to idle with SDA released. Later clocks without a START produce no drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| addr_sel | input | 2 | Strap value for the two low address bits |
| pll_lock | input | 1 | Loop-lock level |
| agc_active | input | 1 | Gain-control-active level |
| adc_code | input | 3 | Converter code |

## Verification
Both bus lines pass through two synchroniser stages and one edge register, and the drive register adds one more stage. A drive change is therefore due three to four system cycles after the SCL falling edge that causes it. The bench holds each SCL phase for eight cycles. It changes its own SDA only while SCL is low and samples the wired-AND line just before it raises SCL low-to-high... more exactly, at the end of each SCL high phase, well after the drive has settled. Release checks after a non-acknowledge or STOP are made at least eight cycles after the triggering edge.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int ADC_W    = 3;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [4:0] ADDR_PREFIX = 5'b11000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_TX,
        ST_MACK
    } st_e;

    typedef struct packed {
        logic             por;
        logic             lock;
        logic [1:0]       ones;
        logic             agc;
        logic [ADC_W-1:0] code;
    } status_t;

    function automatic status_t pack_status(input logic por,
                                            input logic lock,
                                            input logic agc,
                                            input logic [ADC_W-1:0] code);
        status_t s;
        s.por  = por;
        s.lock = lock;
        s.ones = 2'b11;
        s.agc  = agc;
        s.code = code;
        return s;
    endfunction

endpackage

// File: rtl/i2c_stat_sync.sv
module i2c_stat_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_stat_cond.sv
module i2c_stat_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_stat_engine.sv
module i2c_stat_engine
    import i2c_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_c,
    input  logic             stop_c,
    input  logic [1:0]       addr_sel,
    input  logic             pll_lock,
    input  logic             agc_active,
    input  logic [ADC_W-1:0] adc_code,
    output logic             sda_oe
);
    st_e               state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] shadow;
    logic              match;
    logic              por;
    logic              mack;
    status_t           cap;

    always_comb cap = pack_status(por, pll_lock, agc_active, adc_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            rx     <= '0;
            shadow <= '0;
            match  <= 1'b0;
            por    <= 1'b1;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_c) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (stop_c) begin
            state  <= ST_IDLE;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise && cnt < CNT_W'(BYTE_W)) begin
                        rx  <= {rx[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(BYTE_W - 1))
                            match <= ({rx[BYTE_W-2:0], sda_s} == {ADDR_PREFIX, addr_sel, 1'b1});
                    end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                        if (match) begin
                            sda_oe <= 1'b1;
                            state  <= ST_AACK;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        shadow <= cap;
                        sda_oe <= ~cap.por;
                        cnt    <= '0;
                        state  <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_MACK;
                        end else begin
                            shadow <= {shadow[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shadow[BYTE_W-2];
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            por   <= 1'b0;
                            state <= ST_IDLE;
                        end else begin
                            mack  <= 1'b1;
                        end
                    end else if (scl_fall && mack) begin
                        mack   <= 1'b0;
                        shadow <= cap;
                        sda_oe <= ~cap.por;
                        cnt    <= '0;
                        state  <= ST_TX;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive edges never fall inside an SCL high phase.
    assert_sda_low_phase_R4: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // Once cleared, the power-up indicator stays cleared.
    assert_por_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !por |=> !por);

    // Master acknowledge slot is never driven.
    assert_mack_released_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MACK) |-> !sda_oe);

    // A START abandons any transfer and releases the line.
    assert_start_abort_R7: assert property (@(posedge clk) disable iff (rst)
        start_c |=> (state == ST_ADDR) && !sda_oe);

    // Idle means released.
    assert_idle_released_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // Drive begins only in the acknowledge slot or a data byte.
    assert_drive_origin_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> (state == ST_AACK || state == ST_TX));
endmodule

// File: rtl/i2c_stat_port.sv
module i2c_stat_port
    import i2c_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       addr_sel,
    input  logic             pll_lock,
    input  logic             agc_active,
    input  logic [ADC_W-1:0] adc_code
);
    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_c, stop_c;

    i2c_stat_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2c_stat_cond u_cond (
        .clk      (clk),
        .rst      (rst),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    i2c_stat_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_c    (start_c),
        .stop_c     (stop_c),
        .addr_sel   (addr_sel),
        .pll_lock   (pll_lock),
        .agc_active (agc_active),
        .adc_code   (adc_code),
        .sda_oe     (sda_oe)
    );
endmodule

// File: tb/i2c_stat_port_bench.sv
module i2c_stat_port_bench;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic [1:0] addr_sel = 2'b00;
    logic       pll_lock = 1'b0;
    logic       agc_active = 1'b0;
    logic [2:0] adc_code = 3'b000;
    logic       sda_oe;
    wire        sda_line = msda & ~sda_oe;

    int checks = 0;
    int errors = 0;
    logic por_exp = 1'b1;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    i2c_stat_port u_i2c_stat_port (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .addr_sel   (addr_sel),
        .pll_lock   (pll_lock),
        .agc_active (agc_active),
        .adc_code   (adc_code)
    );

    // {sel[1:0], addr7[6:0], rw, lock, agc, code[2:0]}
    localparam logic [14:0] VEC [8] = '{
        {2'b00, 7'b1100000, 1'b1, 1'b1, 1'b0, 3'b101},
        {2'b01, 7'b1100001, 1'b1, 1'b0, 1'b1, 3'b010},
        {2'b10, 7'b1100001, 1'b1, 1'b1, 1'b1, 3'b111},
        {2'b11, 7'b1100011, 1'b0, 1'b1, 1'b1, 3'b111},
        {2'b11, 7'b1100011, 1'b1, 1'b1, 1'b1, 3'b111},
        {2'b00, 7'b1000000, 1'b1, 1'b0, 1'b0, 3'b001},
        {2'b10, 7'b1100010, 1'b1, 1'b0, 1'b0, 3'b000},
        {2'b01, 7'b1100001, 1'b1, 1'b1, 1'b0, 3'b100}
    };

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; scl = 1'b1; msda = 1'b1;
        wait_n(4);
        check(sda_oe == 1'b0, "R1 drive in reset", {7'b0, sda_oe}, 8'h00);
        rst = 1'b0;
        wait_n(H);
        check(sda_oe == 1'b0, "R1 drive after reset", {7'b0, sda_oe}, 8'h00);
        por_exp = 1'b1;
    endtask

    task automatic i2c_start();
        msda = 1'b1; wait_n(H);
        scl = 1'b1;  wait_n(H);
        msda = 1'b0; wait_n(H);
        scl = 1'b0;  wait_n(H);
    endtask

    task automatic i2c_stop();
        msda = 1'b0; wait_n(H);
        scl = 1'b1;  wait_n(H);
        msda = 1'b1; wait_n(H);
    endtask

    task automatic bit_cycle(input logic b, output logic seen);
        msda = b;   wait_n(H);
        scl = 1'b1; wait_n(H);
        seen = sda_line;
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic dummy;
        for (int i = 7; i >= 0; i--) bit_cycle(v[i], dummy);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_cycle(1'b1, v[i]);
    endtask

    function automatic logic [7:0] exp_byte(input logic por, input logic lk, input logic ag, input logic [2:0] cd);
        return {por, lk, 2'b11, ag, cd};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, e, d2;
        logic       b;
        do_reset();

        // Vector table
        for (int i = 0; i < 8; i++) begin
            logic [14:0] v;
            logic        ack_exp;
            v = VEC[i];
            addr_sel = v[14:13]; pll_lock = v[4]; agc_active = v[3]; adc_code = v[2:0];
            ack_exp = (v[12:6] == {5'b11000, v[14:13]}) && v[5];
            i2c_start();
            send_byte(v[12:5]);
            bit_cycle(1'b1, b);
            check(b == !ack_exp, ack_exp ? "R2 address ack" : "R8 no ack", {7'b0, b}, {7'b0, !ack_exp});
            if (ack_exp) begin
                read_byte(d);
                e = exp_byte(por_exp, v[4], v[3], v[2:0]);
                check(d == e, "R3 status byte", d, e);
                bit_cycle(1'b1, b);
                wait_n(H);
                check(sda_oe == 1'b0, "R6 release after nack", {7'b0, sda_oe}, 8'h00);
                por_exp = 1'b0;
            end else begin
                read_byte(d);
                check(d == 8'hFF, "R8 line stays released", d, 8'hFF);
            end
            i2c_stop();
        end

        // R1 / R9: reset, STOP mid-byte
        do_reset();
        addr_sel = 2'b10; pll_lock = 1'b1; agc_active = 1'b0; adc_code = 3'b011;
        i2c_start();
        send_byte({5'b11000, 2'b10, 1'b1});
        bit_cycle(1'b1, b);
        check(b == 1'b0, "R2 ack after reset", {7'b0, b}, 8'h00);
        bit_cycle(1'b1, b);
        check(b == 1'b1, "R1 power-up bit set", {7'b0, b}, 8'h01);
        i2c_stop();
        wait_n(H);
        check(sda_oe == 1'b0, "R9 stop releases", {7'b0, sda_oe}, 8'h00);
        scl = 1'b0;
        read_byte(d);
        check(d == 8'hFF, "R9 idle after stop", d, 8'hFF);
        scl = 1'b1; msda = 1'b1; wait_n(H);

        // R7: repeated START mid-byte keeps power-up flag
        i2c_start();
        send_byte({5'b11000, 2'b10, 1'b1});
        bit_cycle(1'b1, b);
        bit_cycle(1'b1, b);
        i2c_start();
        check(sda_oe == 1'b0, "R7 start releases", {7'b0, sda_oe}, 8'h00);
        send_byte({5'b11000, 2'b10, 1'b1});
        bit_cycle(1'b1, b);
        check(b == 1'b0, "R7 readdress ack", {7'b0, b}, 8'h00);
        read_byte(d);
        e = exp_byte(1'b1, 1'b1, 1'b0, 3'b011);
        check(d == e, "R7 power-up kept", d, e);
        bit_cycle(1'b1, b);
        i2c_stop();

        // R5: multi-byte with mid-byte input change
        pll_lock = 1'b0; agc_active = 1'b1; adc_code = 3'b110;
        i2c_start();
        send_byte({5'b11000, 2'b10, 1'b1});
        bit_cycle(1'b1, b);
        for (int i = 7; i >= 4; i--) bit_cycle(1'b1, d[i]);
        pll_lock = 1'b1; agc_active = 1'b0; adc_code = 3'b001;
        for (int i = 3; i >= 0; i--) bit_cycle(1'b1, d[i]);
        e = exp_byte(1'b0, 1'b0, 1'b1, 3'b110);
        check(d == e, "R5 byte frozen at start", d, e);
        bit_cycle(1'b0, b);
        read_byte(d2);
        e = exp_byte(1'b0, 1'b1, 1'b0, 3'b001);
        check(d2 == e, "R5 fresh second byte", d2, e);
        bit_cycle(1'b1, b);
        wait_n(H);
        check(sda_oe == 1'b0, "R6 release after second byte", {7'b0, sda_oe}, 8'h00);
        i2c_stop();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule